// File: doc/BRIEF.md
# Smart Card Clock and Control Front End

This block is the digital control path between a host controller and a smart card socket. It makes the card clock from the reference clock using a two-bit coded divide ratio. In a synchronous mode it bypasses the divider entirely: a host strobe becomes the card clock and the card reset line follows a host reset input. In asynchronous mode the block runs the card clock and reset itself. The clock runs only while a card session is open. Reset is held asserted for a fixed activation window at the start of each session.

An active-low chip select freezes the control inputs. While it is low, the block uses the values captured at the last clock edge before it fell. It also releases the host-side data lanes and the interrupt drive to their pulled-up idle state. A power-down request reaches its output only outside a card session. A buffered copy of the reference clock is always available. Ratio changes are applied at a falling edge of the divided clock, so the card never sees a shortened clock phase.

Top module: `scard_front`

## Requirements
- R1: In asynchronous mode with a session open, div_sel 2'b00 divides the reference by 8, 2'b01 by 4 and 2'b11 by 2. Across 64 reference cycles, card_clk shows 64/N rising edges.
- R2: In asynchronous mode with a session open, div_sel 2'b10 makes card_clk follow the reference clock: high while clk_ref is high and low while it is low.
- R3: A divide-ratio change is applied only at a falling edge of card_clk. Every high phase therefore lasts exactly as long as the low phase before it, and that length is 1, 2 or 4 reference cycles.
- R4: In asynchronous mode with no session (pwr_cmd_n high), card_clk stops low and card_rst is 0, whatever host_rst and div_sel are.
- R5: In asynchronous mode, card_rst is 0 for the first ACT_CYCLES reference edges of a session. After that it equals host_rst.
- R6: When sync_mode is 1, card_clk equals strobe and card_rst equals host_rst, with no clock delay.
- R7: pd_out is 1 only when pd_req is 1 and pwr_cmd_n is 1. A power-down request during a session has no effect.
- R8: While cs is 1, the control inputs (pwr_cmd_n, host_rst, pd_req, vsel, div_sel, sync_mode) act at once. While cs is 0, the block acts on the values sampled at the last clk_ref edge on which cs was 1.
- R9: While cs is 1, card_tx equals host_tx, host_rx equals card_rx and each bit of host_rx_oe is 1. While cs is 0, card_tx and host_rx are all ones and host_rx_oe is all zeros.
- R10: irq_pull_low is 1 only when cs is 1 and either card_fault is 1 or card_present is 0. Otherwise the interrupt line is released.
- R11: ref_out equals clk_ref in both clock phases.
- R12: card_on is 1 exactly when the effective pwr_cmd_n is 0, and card_5v equals the effective vsel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select; low freezes controls and releases host side |
| pwr_cmd_n | input | 1 | Card power command, low opens a session |
| host_rst | input | 1 | Host reset level for the card |
| pd_req | input | 1 | Power-down request, active high |
| vsel | input | 1 | Card voltage select, 1 = higher supply |
| div_sel | input | 2 | Coded divide ratio |
| sync_mode | input | 1 | 1 = strobe-driven synchronous mode |
| strobe | input | 1 | Host strobe used as card clock in synchronous mode |
| card_present | input | 1 | Card presence, active high |
| card_fault | input | 1 | Fault condition, active high |
| host_tx | input | LANES | Data from host towards card |
| card_rx | input | LANES | Data from card towards host |
| card_clk | output | 1 | Card clock |
| card_rst | output | 1 | Card reset line level |
| card_5v | output | 1 | Effective voltage select |
| card_on | output | 1 | Session active flag |
| pd_out | output | 1 | Granted power-down |
| ref_out | output | 1 | Buffered reference clock |
| card_tx | output | LANES | Data driven to card lanes |
| host_rx | output | LANES | Data driven to host lanes |
| host_rx_oe | output | LANES | Host lane drive enables |
| irq_pull_low | output | 1 | Open-drain interrupt pull-down request |

## Verification
The clocked checks assume that cs and the control inputs change only between reference edges. They also assume that strobe matters only while sync_mode is set. The stimulus meets both by driving every input a few nanoseconds after a rising edge, well clear of both clock edges. The ratio-change check assumes the run request stays steady across a sweep, so the bench keeps the session open while it steps through divide codes.

// File: rtl/scf_pkg.sv
package scf_pkg;

   typedef enum logic [1:0] {
      DIV8   = 2'b00,
      DIV4   = 2'b01,
      DIVBYP = 2'b10,
      DIV2   = 2'b11
   } scf_div_e;

   typedef struct packed {
      logic       pwr_cmd_n;
      logic       host_rst;
      logic       pd_req;
      logic       vsel;
      logic [1:0] div_sel;
      logic       sync_mode;
   } scf_ctrl_t;

   localparam scf_ctrl_t SCF_CTRL_IDLE = '{pwr_cmd_n: 1'b1, host_rst: 1'b0,
                                           pd_req: 1'b0, vsel: 1'b0,
                                           div_sel: 2'b00, sync_mode: 1'b0};

   // last phase-counter value of one half period of the divided clock
   function automatic logic [1:0] scf_half_lim(scf_div_e code);
      case (code)
         DIV8:    return 2'd3;
         DIV4:    return 2'd1;
         default: return 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/scf_latch.sv
module scf_latch
   import scf_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cs,
   input  scf_ctrl_t ctrl_raw,
   output scf_ctrl_t ctrl_eff
);

   scf_ctrl_t held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  held <= SCF_CTRL_IDLE;
      else if (cs) held <= ctrl_raw;
   end

   assign ctrl_eff = cs ? ctrl_raw : held;

   // observation registers for the freeze property
   logic      cs_q;
   scf_ctrl_t eff_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q  <= 1'b1;
         eff_q <= SCF_CTRL_IDLE;
      end else begin
         cs_q  <= cs;
         eff_q <= ctrl_eff;
      end
   end

   p_freeze_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs && !cs_q) |-> (ctrl_eff == eff_q));

endmodule

// File: rtl/scf_div.sv
module scf_div
   import scf_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     run,
   input  scf_div_e req_code,
   output logic     clk_o
);

   localparam int PH_W = 2;

   scf_div_e        act_code;
   logic            div_q;
   logic [PH_W-1:0] ph;
   logic [PH_W-1:0] lim;
   logic            pass_en;

   assign lim = scf_half_lim(act_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_code <= DIV8;
         div_q    <= 1'b0;
         ph       <= '0;
      end else if (act_code == DIVBYP) begin
         if (req_code != DIVBYP) begin
            act_code <= req_code;
            div_q    <= 1'b0;
            ph       <= '0;
         end
      end else if (!div_q) begin
         if (!run) begin
            ph       <= '0;
            act_code <= req_code;
         end else if (ph == lim) begin
            div_q <= 1'b1;
            ph    <= '0;
         end else begin
            ph <= ph + 1'b1;
         end
      end else begin
         if (ph == lim) begin
            div_q    <= 1'b0;
            ph       <= '0;
            act_code <= req_code;
         end else begin
            ph <= ph + 1'b1;
         end
      end
   end

   // pass-through enable moves only while the reference is low
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) pass_en <= 1'b0;
      else        pass_en <= run && (act_code == DIVBYP);
   end

   assign clk_o = pass_en ? clk : div_q;

   p_change_at_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_code) |-> !div_q);

   p_idle_stays_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !div_q) |=> !div_q);

endmodule

// File: rtl/scf_lanes.sv
module scf_lanes #(
   parameter int LANES = 3
) (
   input  logic             cs,
   input  logic [LANES-1:0] host_tx,
   input  logic [LANES-1:0] card_rx,
   input  logic             card_present,
   input  logic             card_fault,
   output logic [LANES-1:0] card_tx,
   output logic [LANES-1:0] host_rx,
   output logic [LANES-1:0] host_rx_oe,
   output logic             irq_pull_low
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign card_tx[g]    = cs ? host_tx[g] : 1'b1;
      assign host_rx[g]    = cs ? card_rx[g] : 1'b1;
      assign host_rx_oe[g] = cs;
   end

   assign irq_pull_low = cs & (card_fault | ~card_present);

endmodule

// File: rtl/scard_front.sv
module scard_front
   import scf_pkg::*;
#(
   parameter int LANES      = 3,
   parameter int ACT_CYCLES = 16
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             cs,
   input  logic             pwr_cmd_n,
   input  logic             host_rst,
   input  logic             pd_req,
   input  logic             vsel,
   input  logic [1:0]       div_sel,
   input  logic             sync_mode,
   input  logic             strobe,
   input  logic             card_present,
   input  logic             card_fault,
   input  logic [LANES-1:0] host_tx,
   input  logic [LANES-1:0] card_rx,
   output logic             card_clk,
   output logic             card_rst,
   output logic             card_5v,
   output logic             card_on,
   output logic             pd_out,
   output logic             ref_out,
   output logic [LANES-1:0] card_tx,
   output logic [LANES-1:0] host_rx,
   output logic [LANES-1:0] host_rx_oe,
   output logic             irq_pull_low
);

   localparam int CNT_W = $clog2(ACT_CYCLES + 1);

   if (LANES < 1) begin : g_bad_lanes
      $error("scard_front: LANES must be at least 1");
   end
   if (ACT_CYCLES < 1) begin : g_bad_act
      $error("scard_front: ACT_CYCLES must be at least 1");
   end

   scf_ctrl_t ctrl_raw, eff;
   assign ctrl_raw = '{pwr_cmd_n: pwr_cmd_n, host_rst: host_rst, pd_req: pd_req,
                       vsel: vsel, div_sel: div_sel, sync_mode: sync_mode};

   scf_latch i_latch (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .cs       (cs),
      .ctrl_raw (ctrl_raw),
      .ctrl_eff (eff)
   );

   logic session;
   logic div_run;
   logic div_clk;
   assign session = ~eff.pwr_cmd_n;
   assign div_run = session & ~eff.sync_mode;

   scf_div i_div (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .run      (div_run),
      .req_code (scf_div_e'(eff.div_sel)),
      .clk_o    (div_clk)
   );

   // activation window counter
   logic [CNT_W-1:0] act_cnt;
   logic             act_done;
   assign act_done = (act_cnt == CNT_W'(ACT_CYCLES));

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n)                  act_cnt <= '0;
      else if (!div_run)           act_cnt <= '0;
      else if (!act_done)          act_cnt <= act_cnt + 1'b1;
   end

   assign card_clk = eff.sync_mode ? strobe : div_clk;
   assign card_rst = eff.sync_mode ? eff.host_rst
                                   : (session & act_done & eff.host_rst);
   assign card_on  = session;
   assign card_5v  = eff.vsel;
   assign pd_out   = eff.pd_req & eff.pwr_cmd_n;
   assign ref_out  = clk_ref;

   scf_lanes #(.LANES(LANES)) i_lanes (
      .cs           (cs),
      .host_tx      (host_tx),
      .card_rx      (card_rx),
      .card_present (card_present),
      .card_fault   (card_fault),
      .card_tx      (card_tx),
      .host_rx      (host_rx),
      .host_rx_oe   (host_rx_oe),
      .irq_pull_low (irq_pull_low)
   );

   p_rst_wait_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
      ($rose(card_on) && !eff.sync_mode) |-> !card_rst);

   p_pd_blocked_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
      card_on |-> !pd_out);

   p_lane_release_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !cs |-> ((&card_tx) && (&host_rx) && !(|host_rx_oe)));

   p_irq_release_r10: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !cs |-> !irq_pull_low);

endmodule

// File: tb/test_scard_front.sv
`timescale 1ns/1ps
module test_scard_front;

   localparam int LANES = 3;
   localparam int ACT   = 16;

   logic clk_ref = 1'b0;
   logic rst_n, cs, pwr_cmd_n, host_rst, pd_req, vsel, sync_mode, strobe;
   logic card_present, card_fault;
   logic [1:0] div_sel;
   logic [LANES-1:0] host_tx, card_rx;
   logic card_clk, card_rst, card_5v, card_on, pd_out, ref_out, irq_pull_low;
   logic [LANES-1:0] card_tx, host_rx, host_rx_oe;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #5 clk_ref = ~clk_ref;

   scard_front #(.LANES(LANES), .ACT_CYCLES(ACT)) i_scard_front (
      .clk_ref(clk_ref), .rst_n(rst_n), .cs(cs), .pwr_cmd_n(pwr_cmd_n),
      .host_rst(host_rst), .pd_req(pd_req), .vsel(vsel), .div_sel(div_sel),
      .sync_mode(sync_mode), .strobe(strobe), .card_present(card_present),
      .card_fault(card_fault), .host_tx(host_tx), .card_rx(card_rx),
      .card_clk(card_clk), .card_rst(card_rst), .card_5v(card_5v),
      .card_on(card_on), .pd_out(pd_out), .ref_out(ref_out),
      .card_tx(card_tx), .host_rx(host_rx), .host_rx_oe(host_rx_oe),
      .irq_pull_low(irq_pull_low));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk_ref);
         #3;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   int rises;
   logic prev;
   int exp_r;
   int runlen, lowlen, phases, bad;
   logic [1:0] pat [3];

   initial begin
      rst_n = 0; cs = 1; pwr_cmd_n = 1; host_rst = 0; pd_req = 0; vsel = 0;
      div_sel = 2'b00; sync_mode = 0; strobe = 0; card_present = 1; card_fault = 0;
      host_tx = '0; card_rx = '0;
      #23;
      // reset state (R4)
      chk("R4 reset card_clk", card_clk, 0);
      chk("R4 reset card_rst", card_rst, 0);
      chk("R12 reset card_on", card_on, 0);
      rst_n = 1;
      tick(2);

      // R4: idle async, host_rst high, every code
      host_rst = 1;
      for (int c = 0; c < 4; c++) begin
         div_sel = 2'(c);
         tick(3);
         chk("R4 idle card_clk", card_clk, 0);
         chk("R4 idle card_rst", card_rst, 0);
      end

      // R11: reference buffer
      chk("R11 ref high", ref_out, 1);
      #5 chk("R11 ref low", ref_out, 0);
      tick(1);

      // R12 pass-through
      vsel = 1; #1 chk("R12 card_5v", card_5v, 1);
      vsel = 0; #1 chk("R12 card_5v", card_5v, 0);

      // R7 power-down sweep
      for (int v = 0; v < 4; v++) begin
         pd_req = v[0]; pwr_cmd_n = v[1];
         #1 chk("R7 pd_out", pd_out, v[0] & v[1]);
      end
      pd_req = 0; pwr_cmd_n = 1;
      tick(2);

      // R5: activation window
      div_sel = 2'b11; host_rst = 1;
      pwr_cmd_n = 0;
      #1 chk("R12 card_on", card_on, 1);
      chk("R5 rst at start", card_rst, 0);
      tick(10);
      chk("R5 rst inside window", card_rst, 0);
      tick(10);
      chk("R5 rst after window", card_rst, 1);
      host_rst = 0;
      #1 chk("R5 rst follows host", card_rst, 0);
      host_rst = 1;
      #1 chk("R5 rst follows host", card_rst, 1);

      // R1: divide ratios
      foreach (pat[k]) ;
      pat[0] = 2'b00; pat[1] = 2'b01; pat[2] = 2'b11;
      for (int k = 0; k < 3; k++) begin
         div_sel = pat[k];
         tick(24);
         rises = 0; prev = card_clk;
         for (int i = 0; i < 64; i++) begin
            tick(1);
            if (card_clk && !prev) rises++;
            prev = card_clk;
         end
         exp_r = (pat[k] == 2'b00) ? 8 : (pat[k] == 2'b01) ? 16 : 32;
         chk("R1 rising edges", rises, exp_r);
      end

      // R2: undivided pass-through
      div_sel = 2'b10;
      tick(12);
      for (int i = 0; i < 6; i++) begin
         tick(1);
         chk("R2 card_clk high phase", card_clk, 1);
         #5 chk("R2 card_clk low phase", card_clk, 0);
      end
      div_sel = 2'b01;
      tick(20);
      rises = 0; prev = card_clk;
      for (int i = 0; i < 64; i++) begin
         tick(1);
         if (card_clk && !prev) rises++;
         prev = card_clk;
      end
      chk("R1 after leaving pass-through", rises, 16);

      // R3: ratio changes never shorten a phase
      runlen = 0; lowlen = 0; phases = 0; bad = 0; prev = card_clk;
      for (int i = 0; i < 300; i++) begin
         div_sel = pat[(i / 7) % 3];
         tick(1);
         if (card_clk === prev) runlen++;
         else begin
            runlen++;
            phases++;
            if (phases > 2) begin
               if (!(runlen == 1 || runlen == 2 || runlen == 4)) bad++;
               if (prev == 1'b1 && runlen != lowlen) bad++;
            end
            if (prev == 1'b0) lowlen = runlen;
            runlen = 0;
            prev = card_clk;
         end
      end
      chk("R3 phase length violations", bad, 0);
      chk("R3 phases seen", phases > 40, 1);

      // R4: session end stops the clock low
      pwr_cmd_n = 1;
      #1 chk("R4 rst at session end", card_rst, 0);
      tick(10);
      for (int i = 0; i < 8; i++) begin
         tick(1);
         chk("R4 clk stopped", card_clk, 0);
      end

      // R6: synchronous mode
      sync_mode = 1;
      for (int v = 0; v < 4; v++) begin
         strobe = v[0]; host_rst = v[1];
         #1 chk("R6 card_clk", card_clk, v[0]);
         chk("R6 card_rst", card_rst, v[1]);
      end

      // R8: freeze under cs low
      sync_mode = 1; host_rst = 1; vsel = 0; pwr_cmd_n = 1; pd_req = 1;
      tick(1);
      cs = 0;
      sync_mode = 0; host_rst = 0; vsel = 1; pwr_cmd_n = 0; pd_req = 0; div_sel = 2'b00;
      tick(3);
      chk("R8 frozen card_5v", card_5v, 0);
      chk("R8 frozen pd_out", pd_out, 1);
      chk("R8 frozen card_on", card_on, 0);
      chk("R8 frozen card_rst", card_rst, 1);
      strobe = 1; #1 chk("R8 frozen sync mode", card_clk, 1);
      strobe = 0; #1 chk("R8 frozen sync mode", card_clk, 0);
      cs = 1;
      #1 chk("R8 live card_5v", card_5v, 1);
      chk("R8 live card_on", card_on, 1);
      chk("R8 live pd_out", pd_out, 0);
      pwr_cmd_n = 1;
      tick(2);

      // R9: lanes, exhaustive
      for (int c = 0; c < 2; c++) begin
         cs = c[0];
         for (int v = 0; v < 64; v++) begin
            host_tx = v[2:0]; card_rx = v[5:3];
            #1;
            chk("R9 card_tx", card_tx, c ? v[2:0] : 3'b111);
            chk("R9 host_rx", host_rx, c ? v[5:3] : 3'b111);
            chk("R9 host_rx_oe", host_rx_oe, c ? 3'b111 : 3'b000);
         end
      end

      // R10: interrupt, exhaustive
      for (int v = 0; v < 8; v++) begin
         cs = v[0]; card_fault = v[1]; card_present = v[2];
         #1 chk("R10 irq_pull_low", irq_pull_low, v[0] & (v[1] | ~v[2]));
      end
      cs = 1; card_fault = 0; card_present = 1;
      tick(2);

      finish_run();
   end

endmodule